// File: doc/BRIEF.md
# Dual-Path SPI Serial Clock Divider

This block turns a fast source clock into the timing for an SPI serial clock. It does not make a new clock. It produces a one-cycle tick at every half period of the serial clock, so that a shifter can act on both the launch edge and the capture edge. It also produces a registered serial-clock level that toggles on each tick while a burst is in progress.

Two divider laws are built side by side, and a select input picks one of them. The binary path divides the source by four and then by a power of two taken from a 3-bit code. The linear path divides the source by two and then by one plus an 8-bit code. The block reads the configuration fields directly as inputs. It adopts a new setting only at the end of a full serial-clock period, so a reconfiguration never shortens a high or low phase. While the controller enable is low, the counter is held cleared and the block outputs nothing.

Top module: `dual_sck_divider`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `halfTick` and `sckOut` are both 0.
- R2: With `pathSel` = 0, ticks are 2^(powCode+1) source cycles apart, so the serial-clock period is 4·2^powCode. Codes 0, 1, 2 and 3 give periods of 4, 8, 16 and 32 cycles, and code 7 gives ticks 256 cycles apart.
- R3: With `pathSel` = 1, ticks are enhCode+1 source cycles apart, so the serial-clock period is 2·(enhCode+1). Code 0 gives a tick on every cycle, and code 255 gives ticks 256 cycles apart.
- R4: The code field of the path that is not selected has no effect on tick timing.
- R5: While `enable` is low, `halfTick` and `sckOut` read 0 from the next cycle on, and the divisor is captured from the inputs. After `enable` rises, the first tick appears one half period (in cycles) after the first enabled clock edge.
- R6: A change of `pathSel`, `powCode` or `enhCode` while the block is enabled is adopted only at a tick that ends the second half of a serial-clock period. Counting ticks from 1 after enable, these are the even-numbered ticks. The interval after the adopting tick uses the new length.
- R7: `sckOut` changes only together with a tick while the block is enabled. On a tick it inverts if `busy` is 1 and returns to 0 if `busy` is 0. Starting from idle with `busy` held at 1, it reads 1 after odd-numbered ticks and 0 after even-numbered ticks.
- R8: When the half period is longer than one cycle, `halfTick` stays high for exactly one cycle. With a half period of one cycle, it stays high continuously.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Controller enable; low clears the divider |
| busy | input | 1 | Burst in progress; lets the serial clock toggle |
| pathSel | input | 1 | 1 selects the linear path, 0 selects the binary path |
| powCode | input | POW_W (3) | Exponent code for the binary path |
| enhCode | input | ENH_W (8) | Code for the linear path |
| halfTick | output | 1 | One-cycle strobe at each serial-clock half period |
| sckOut | output | 1 | Registered serial-clock level |

## Verification
Both outputs come from registers that update on the same edge. After `enable` is driven at a falling edge, the first tick shows up L falling edges later, where L is the half period in cycles. Each later tick follows the previous one by L samples. The bench therefore counts falling-edge samples between ticks and compares each count with L. Right after each tick it reads `sckOut` and compares it with the tick parity. It also confirms that `sckOut` did not move at any sample between ticks. For a field change or a disable, the bench applies the change at a known tick position. It then expects the old interval up to the next even tick, and the disabled state one sample after `enable` falls.

// File: rtl/sckdiv_pkg.sv
package sckdiv_pkg;
  // Strobes from the control to the half-period counter
  typedef struct packed {
    logic clear;    // hold the counter at zero (block disabled)
    logic restart;  // half period finished, start counting again
  } cntStrobe_t;
endpackage

// File: rtl/sckdiv_law.sv
// Combinational front end: turns the selected code into a half-period
// limit (half period in source cycles, minus one).
module sckdiv_law #(
  parameter int POW_W = 3,
  parameter int ENH_W = 8,
  parameter int LIM_W = 8
) (
  input  logic             pathSel,
  input  logic [POW_W-1:0] powCode,
  input  logic [ENH_W-1:0] enhCode,
  output logic [LIM_W-1:0] newLimit
);
  logic [LIM_W:0]   powSpan;
  logic [LIM_W-1:0] powLimit;
  logic [LIM_W-1:0] enhLimit;

  always_comb begin
    // half period of the binary path is 2^(code+1) cycles
    powSpan  = (LIM_W+1)'(2) << powCode;
    powLimit = LIM_W'(powSpan - 1'b1);
    // half period of the linear path is code+1 cycles
    enhLimit = LIM_W'(enhCode);
    newLimit = pathSel ? enhLimit : powLimit;
  end
endmodule

// File: rtl/sckdiv_dpath.sv
// Half-period counter.
module sckdiv_dpath
  import sckdiv_pkg::*;
#(
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrobe_t       strobe,
  input  logic [LIM_W-1:0] limit,
  output logic             atEnd
);
  logic [LIM_W-1:0] cntQ;

  assign atEnd = (cntQ == limit);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (strobe.clear || strobe.restart) begin
      cntQ <= '0;
    end else begin
      cntQ <= cntQ + 1'b1;
    end
  end

  // R8: the count never runs past the limit held by the control
  a_r8_count_in_range: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= limit);
endmodule

// File: rtl/sckdiv_ctrl.sv
// Control: owns the active limit, the half-period phase, the tick and the
// serial-clock level.
module sckdiv_ctrl
  import sckdiv_pkg::*;
#(
  parameter int LIM_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             busy,
  input  logic [LIM_W-1:0] newLimit,
  input  logic             atEnd,
  output cntStrobe_t       strobe,
  output logic [LIM_W-1:0] activeLimit,
  output logic             tick,
  output logic             sck
);
  logic [LIM_W-1:0] limitQ;
  logic             phaseQ;   // 1 while in the second half of a period
  logic             tickQ;
  logic             sckQ;

  always_comb begin
    strobe.clear   = !enable;
    strobe.restart = enable && atEnd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      limitQ <= '0;
      phaseQ <= 1'b0;
      tickQ  <= 1'b0;
      sckQ   <= 1'b0;
    end else if (!enable) begin
      limitQ <= newLimit;
      phaseQ <= 1'b0;
      tickQ  <= 1'b0;
      sckQ   <= 1'b0;
    end else begin
      tickQ <= atEnd;
      if (atEnd) begin
        phaseQ <= !phaseQ;
        if (phaseQ) limitQ <= newLimit;
        sckQ <= busy ? !sckQ : 1'b0;
      end
    end
  end

  assign activeLimit = limitQ;
  assign tick        = tickQ;
  assign sck         = sckQ;

  // R5: a disabled cycle leaves both outputs low
  a_r5_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !$past(enable) |-> (!tickQ && !sckQ));

  // R7: while enabled, the level moves only together with a tick
  a_r7_level_moves_on_tick: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enable) && !$stable(sckQ)) |-> tickQ);

  // R6: the active limit is replaced only at a tick that closes a period
  a_r6_reload_at_period_end: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enable) && !$stable(limitQ)) |-> (tickQ && !phaseQ));

  // R8: a tick lasts one cycle unless the half period is a single cycle
  a_r8_single_cycle_tick: assert property (@(posedge clk) disable iff (!rstN)
    (tickQ && (limitQ != '0) && enable) |=> !tickQ);
endmodule

// File: rtl/dual_sck_divider.sv
// Thin top: divisor law, control and half-period counter.
module dual_sck_divider
  import sckdiv_pkg::*;
#(
  parameter int POW_W = 3,
  parameter int ENH_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             busy,
  input  logic             pathSel,
  input  logic [POW_W-1:0] powCode,
  input  logic [ENH_W-1:0] enhCode,
  output logic             halfTick,
  output logic             sckOut
);
  localparam int POW_LIM_W = 1 << POW_W;
  localparam int LIM_W = (POW_LIM_W > ENH_W) ? POW_LIM_W : ENH_W;

  logic [LIM_W-1:0] newLimit;
  logic [LIM_W-1:0] activeLimit;
  logic             atEnd;
  cntStrobe_t       strobe;

  sckdiv_law #(.POW_W(POW_W), .ENH_W(ENH_W), .LIM_W(LIM_W)) law_i (
    .pathSel  (pathSel),
    .powCode  (powCode),
    .enhCode  (enhCode),
    .newLimit (newLimit)
  );

  sckdiv_ctrl #(.LIM_W(LIM_W)) ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .busy        (busy),
    .newLimit    (newLimit),
    .atEnd       (atEnd),
    .strobe      (strobe),
    .activeLimit (activeLimit),
    .tick        (halfTick),
    .sck         (sckOut)
  );

  sckdiv_dpath #(.LIM_W(LIM_W)) dpath_i (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .limit  (activeLimit),
    .atEnd  (atEnd)
  );
endmodule

// File: tb/dual_sck_divider_tb_top.sv
module dual_sck_divider_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       busy = 1'b0;
  logic       pathSel = 1'b0;
  logic [2:0] powCode = '0;
  logic [7:0] enhCode = '0;
  logic       halfTick;
  logic       sckOut;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  dual_sck_divider dut_i (
    .clk(clk), .rstN(rstN), .enable(enable), .busy(busy),
    .pathSel(pathSel), .powCode(powCode), .enhCode(enhCode),
    .halfTick(halfTick), .sckOut(sckOut)
  );

  typedef struct packed {
    logic       sel;
    logic [2:0] pc;
    logic [7:0] ec;
    logic [31:0] half;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{1'b0, 3'd0, 8'h55, 32'd2},
    '{1'b0, 3'd1, 8'h00, 32'd4},
    '{1'b0, 3'd3, 8'h07, 32'd16},
    '{1'b0, 3'd7, 8'h01, 32'd256},
    '{1'b1, 3'd7, 8'd0,  32'd1},
    '{1'b1, 3'd0, 8'd9,  32'd10},
    '{1'b1, 3'd2, 8'd255, 32'd256},
    '{1'b1, 3'd5, 8'd2,  32'd3}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Counts falling-edge samples up to the next tick; flags a level move in between
  task automatic nextTick(output int gap, output bit slip);
    logic startSck;
    startSck = sckOut;
    gap = 0;
    slip = 1'b0;
    do begin
      @(negedge clk);
      gap++;
      if (!halfTick && sckOut !== startSck) slip = 1'b1;
    end while (!halfTick && gap < 2000);
  endtask

  task automatic restart(input logic sel, input logic [2:0] pc, input logic [7:0] ec, input logic b);
    @(negedge clk);
    enable = 1'b0;
    pathSel = sel; powCode = pc; enhCode = ec; busy = b;
    repeat (2) @(negedge clk);
    enable = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog (all requirements) actual=expired expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int gap;
    bit slip;
    // R1: reset state
    repeat (3) @(negedge clk);
    check(halfTick == 1'b0 && sckOut == 1'b0, "R1 reset outputs", {halfTick, sckOut}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(halfTick == 1'b0 && sckOut == 1'b0, "R1 after reset", {halfTick, sckOut}, 0);

    // R5: disabled block stays quiet
    begin
      int seen = 0;
      busy = 1'b1; pathSel = 1'b1; enhCode = 8'd0;
      for (int c = 0; c < 40; c++) begin
        @(negedge clk);
        if (halfTick || sckOut) seen++;
      end
      check(seen == 0, "R5 quiet while disabled", seen, 0);
    end

    // R2 R3 R7 R8: table of laws
    for (int v = 0; v < 8; v++) begin
      restart(VECS[v].sel, VECS[v].pc, VECS[v].ec, 1'b1);
      for (int k = 1; k <= 4; k++) begin
        nextTick(gap, slip);
        check(gap == int'(VECS[v].half), VECS[v].sel ? "R3 linear interval (R8)" : "R2 binary interval (R8)",
              gap, int'(VECS[v].half));
        check(sckOut == logic'(k % 2) && !slip, "R7 level parity", sckOut, k % 2);
      end
    end

    // R4: unselected field ignored
    restart(1'b0, 3'd1, 8'd20, 1'b1);
    nextTick(gap, slip);
    enhCode = 8'd0;
    for (int k = 0; k < 5; k++) begin
      nextTick(gap, slip);
      check(gap == 4, "R4 unselected code ignored", gap, 4);
    end

    // R6: change after tick 1 adopted at tick 2
    restart(1'b1, 3'd0, 8'd3, 1'b1);
    nextTick(gap, slip);
    enhCode = 8'd1;
    nextTick(gap, slip);
    check(gap == 4, "R6 old length until period end", gap, 4);
    nextTick(gap, slip);
    check(gap == 2, "R6 new length after tick 2", gap, 2);
    nextTick(gap, slip);
    check(gap == 2, "R6 new length kept", gap, 2);

    // R6: change after tick 2 waits for tick 4
    restart(1'b1, 3'd0, 8'd3, 1'b1);
    nextTick(gap, slip);
    nextTick(gap, slip);
    enhCode = 8'd1;
    nextTick(gap, slip);
    check(gap == 4, "R6 tick 3 interval", gap, 4);
    nextTick(gap, slip);
    check(gap == 4, "R6 tick 4 interval", gap, 4);
    nextTick(gap, slip);
    check(gap == 2, "R6 tick 5 interval", gap, 2);

    // R6: path switch deferred too
    restart(1'b1, 3'd0, 8'd5, 1'b1);
    nextTick(gap, slip);
    pathSel = 1'b0; powCode = 3'd0;
    nextTick(gap, slip);
    check(gap == 6, "R6 path switch deferred", gap, 6);
    nextTick(gap, slip);
    check(gap == 2, "R6 path switch adopted", gap, 2);

    // R7: busy low keeps idle level, busy gating
    restart(1'b1, 3'd0, 8'd2, 1'b0);
    for (int k = 0; k < 3; k++) begin
      nextTick(gap, slip);
      check(sckOut == 1'b0 && !slip, "R7 idle while not busy", sckOut, 0);
    end
    busy = 1'b1;
    nextTick(gap, slip);
    check(sckOut == 1'b1 && !slip, "R7 toggle high", sckOut, 1);
    busy = 1'b0;
    nextTick(gap, slip);
    check(sckOut == 1'b0 && !slip, "R7 return to idle on tick", sckOut, 0);

    // R5: disable mid-run and restart
    restart(1'b1, 3'd0, 8'd4, 1'b1);
    nextTick(gap, slip);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(halfTick == 1'b0 && sckOut == 1'b0, "R5 cleared by disable", {halfTick, sckOut}, 0);
    @(negedge clk);
    enable = 1'b1;
    nextTick(gap, slip);
    check(gap == 5, "R5 first tick after re-enable", gap, 5);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule